// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small write-back, write-allocate data cache. Its primary store is direct mapped: each address selects exactly one line slot. Beside it sits a tiny fully associative victim buffer. Lines enter that buffer only when the primary store pushes them out. The buffer is never loaded by fills from memory.

When a request misses in the primary store, the victim buffer is searched before the next memory level is touched. On a victim hit, the wanted line and the line occupying its primary slot trade places in one swap step, and no memory traffic takes place. On a full miss, the current primary line is pushed into the victim buffer at its FIFO position. If the entry pushed out from that position is dirty, it is written back to memory first. The missing line is then fetched as a whole line and placed in the primary slot.

The processor side takes one request at a time through a valid/ready handshake, and each completed request gives a single-cycle response pulse. The memory side carries line-wide read and write requests with a valid/ready handshake. A read returns one line on a response strobe, and a write gets no reply.

Top module: `vc_cache_top`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line in both structures is invalid, so the first access to any address is a full miss.
- R2: A primary hit accepted at a clock edge raises `resp_valid` right after that edge, one cycle of latency, and issues no memory request.
- R3: A write hit updates only the addressed word of the cached line, marks the line dirty and sends nothing to memory. A write miss fetches the line and then merges the written word into it.
- R4: On a primary miss the victim buffer is searched first. A victim hit responds two cycles after acceptance and issues no memory request.
- R5: On a victim hit the line displaced from the primary slot takes the hit entry's place in the victim buffer, so an access to it right afterwards is itself a two-cycle victim hit.
- R6: A line fetched from memory goes only into the primary store. A repeat access to it is a one-cycle primary hit.
- R7: The victim buffer has 4 entries, filled in FIFO order by full-miss evictions. When a valid entry is overwritten, it is written back to memory as a full line at its own line address (word address shifted right by 2) only if it is dirty. A clean entry is dropped silently.
- R8: While a miss is in progress, `req_ready` is 0. A memory read carries the line address of the request (word address bits [11:2]). A memory request held without `mem_req_ready` keeps its address and direction.
- R9: A read returns the most recently written value of the word, whether the line sits in the primary store, in the victim buffer or back in memory. Addresses are word addresses split into tag [11:6], index [5:2] and word offset [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid with `resp_valid` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 10 | Line address |
| mem_req_wdata | output | 128 | Line data for a write-back |
| mem_resp_valid | input | 1 | Read line returned |
| mem_resp_rdata | input | 128 | Returned line |

## Verification
Two actions can land in one cycle: the write-back of the oldest victim entry and the insertion of the evicted primary line into that same entry. The bench provokes this by running six conflicting lines through one index, so that the FIFO wraps onto a dirty entry. It then judges the result by checking that the written-back line carries the old entry's address and its merged data, not the incoming line's. A later read of the written-back line must return the merged word from memory. A further wrap, this time onto a clean entry, must produce no write at all.

// File: rtl/vc_pkg.sv
package vc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SWAP,
      ST_EVICT,
      ST_FETCH,
      ST_WAIT
   } vc_state_e;
endpackage

// File: rtl/vc_primary_array.sv
module vc_primary_array #(
   parameter int LINES  = 16,
   parameter int TAG_W  = 6,
   parameter int LINE_W = 128,
   parameter int IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_data,
   input  logic              wr_dirty
);
   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end
endmodule

// File: rtl/vc_victim_buffer.sv
module vc_victim_buffer #(
   parameter int ENTRIES = 4,
   parameter int LA_W    = 10,
   parameter int LINE_W  = 128,
   parameter int SEL_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   lk_addr,
   output logic              lk_hit,
   output logic [SEL_W-1:0]  lk_sel,
   output logic [LINE_W-1:0] lk_data,
   output logic              lk_dirty,
   output logic [SEL_W-1:0]  head_sel,
   output logic              head_valid,
   output logic              head_dirty,
   output logic [LA_W-1:0]   head_addr,
   output logic [LINE_W-1:0] head_data,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_valid,
   input  logic [LA_W-1:0]   wr_addr,
   input  logic [LINE_W-1:0] wr_data,
   input  logic              wr_dirty,
   input  logic              push
);
   localparam logic [SEL_W-1:0] LAST = SEL_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] dirty_q;
   logic [LA_W-1:0]    addr_q [ENTRIES];
   logic [LINE_W-1:0]  data_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [SEL_W-1:0]   ptr_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = valid_q[e] && (addr_q[e] == lk_addr);
   end

   always_comb begin
      lk_sel = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match[e]) lk_sel = SEL_W'(e);
      end
   end

   assign lk_hit     = |match;
   assign lk_data    = data_q[lk_sel];
   assign lk_dirty   = dirty_q[lk_sel];
   assign head_sel   = ptr_q;
   assign head_valid = valid_q[ptr_q];
   assign head_dirty = dirty_q[ptr_q];
   assign head_addr  = addr_q[ptr_q];
   assign head_data  = data_q[ptr_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         ptr_q   <= '0;
      end else begin
         if (wr_en) begin
            valid_q[wr_sel] <= wr_valid;
            dirty_q[wr_sel] <= wr_dirty && wr_valid;
         end
         if (push) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         addr_q[wr_sel] <= wr_addr;
         data_q[wr_sel] <= wr_data;
      end
   end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
   import vc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int OFF_W   = 2,
   parameter int IDX_W   = 4,
   parameter int SEL_W   = 2,
   parameter int TAG_W   = ADDR_W - OFF_W - IDX_W,
   parameter int LA_W    = ADDR_W - OFF_W,
   parameter int LINE_W  = DATA_W << OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [LA_W-1:0]   mem_req_addr,
   output logic [LINE_W-1:0] mem_req_wdata,
   input  logic              mem_resp_valid,
   input  logic [LINE_W-1:0] mem_resp_rdata,
   output logic [IDX_W-1:0]  pri_rd_idx,
   input  logic              pri_rd_valid,
   input  logic              pri_rd_dirty,
   input  logic [TAG_W-1:0]  pri_rd_tag,
   input  logic [LINE_W-1:0] pri_rd_data,
   output logic              pri_wr_en,
   output logic [IDX_W-1:0]  pri_wr_idx,
   output logic [TAG_W-1:0]  pri_wr_tag,
   output logic [LINE_W-1:0] pri_wr_data,
   output logic              pri_wr_dirty,
   output logic [LA_W-1:0]   vic_lk_addr,
   input  logic              vic_lk_hit,
   input  logic [SEL_W-1:0]  vic_lk_sel,
   input  logic [LINE_W-1:0] vic_lk_data,
   input  logic              vic_lk_dirty,
   input  logic [SEL_W-1:0]  vic_head_sel,
   input  logic              vic_head_valid,
   input  logic              vic_head_dirty,
   input  logic [LA_W-1:0]   vic_head_addr,
   input  logic [LINE_W-1:0] vic_head_data,
   output logic              vic_wr_en,
   output logic [SEL_W-1:0]  vic_wr_sel,
   output logic              vic_wr_valid,
   output logic [LA_W-1:0]   vic_wr_addr,
   output logic [LINE_W-1:0] vic_wr_data,
   output logic              vic_wr_dirty,
   output logic              vic_push
);
   vc_state_e         state_q, state_d;
   logic              q_write;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic              resp_q;
   logic [DATA_W-1:0] rdata_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [OFF_W-1:0]  cur_off;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   logic [LA_W-1:0]   cur_la;
   logic              cur_write;
   logic [DATA_W-1:0] cur_wdata;
   logic              pri_hit;
   logic              need_wb;
   logic              resp_set;
   logic [LINE_W-1:0] resp_line;

   function automatic logic [LINE_W-1:0] merge_word(
      input logic [LINE_W-1:0] line,
      input logic [OFF_W-1:0]  off,
      input logic [DATA_W-1:0] word,
      input logic              en
   );
      logic [LINE_W-1:0] r;
      r = line;
      if (en) r[off*DATA_W +: DATA_W] = word;
      return r;
   endfunction

   assign cur_addr  = (state_q == ST_IDLE) ? req_addr  : q_addr;
   assign cur_write = (state_q == ST_IDLE) ? req_write : q_write;
   assign cur_wdata = (state_q == ST_IDLE) ? req_wdata : q_wdata;
   assign cur_off   = cur_addr[OFF_W-1:0];
   assign cur_idx   = cur_addr[OFF_W +: IDX_W];
   assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
   assign cur_la    = cur_addr[ADDR_W-1:OFF_W];

   assign pri_rd_idx  = cur_idx;
   assign vic_lk_addr = cur_la;
   assign pri_hit     = pri_rd_valid && (pri_rd_tag == cur_tag);
   assign need_wb     = vic_head_valid && vic_head_dirty;
   assign req_ready   = (state_q == ST_IDLE);
   assign resp_valid  = resp_q;
   assign resp_rdata  = rdata_q;

   always_comb begin
      state_d       = state_q;
      pri_wr_en     = 1'b0;
      pri_wr_idx    = cur_idx;
      pri_wr_tag    = cur_tag;
      pri_wr_data   = pri_rd_data;
      pri_wr_dirty  = 1'b0;
      vic_wr_en     = 1'b0;
      vic_wr_sel    = vic_head_sel;
      vic_wr_valid  = pri_rd_valid;
      vic_wr_addr   = {pri_rd_tag, cur_idx};
      vic_wr_data   = pri_rd_data;
      vic_wr_dirty  = pri_rd_dirty;
      vic_push      = 1'b0;
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = cur_la;
      mem_req_wdata = vic_head_data;
      resp_set      = 1'b0;
      resp_line     = pri_rd_data;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (pri_hit) begin
                  resp_line    = merge_word(pri_rd_data, cur_off, cur_wdata, cur_write);
                  pri_wr_en    = cur_write;
                  pri_wr_data  = resp_line;
                  pri_wr_dirty = 1'b1;
                  resp_set     = 1'b1;
               end else if (vic_lk_hit) begin
                  state_d = ST_SWAP;
               end else begin
                  state_d = ST_EVICT;
               end
            end
         end
         ST_SWAP: begin
            resp_line    = merge_word(vic_lk_data, cur_off, cur_wdata, cur_write);
            pri_wr_en    = 1'b1;
            pri_wr_data  = resp_line;
            pri_wr_dirty = vic_lk_dirty || cur_write;
            vic_wr_en    = 1'b1;
            vic_wr_sel   = vic_lk_sel;
            resp_set     = 1'b1;
            state_d      = ST_IDLE;
         end
         ST_EVICT: begin
            if (!pri_rd_valid) begin
               state_d = ST_FETCH;
            end else begin
               mem_req_valid = need_wb;
               mem_req_write = 1'b1;
               mem_req_addr  = vic_head_addr;
               if (!need_wb || mem_req_ready) begin
                  vic_wr_en = 1'b1;
                  vic_push  = 1'b1;
                  state_d   = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (mem_resp_valid) begin
               resp_line    = merge_word(mem_resp_rdata, cur_off, cur_wdata, cur_write);
               pri_wr_en    = 1'b1;
               pri_wr_data  = resp_line;
               pri_wr_dirty = cur_write;
               resp_set     = 1'b1;
               state_d      = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         resp_q  <= 1'b0;
         q_write <= 1'b0;
         q_addr  <= '0;
         q_wdata <= '0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         resp_q  <= resp_set;
         if (resp_set) rdata_q <= resp_line[cur_off*DATA_W +: DATA_W];
         if (state_q == ST_IDLE && req_valid) begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
         end
      end
   end
endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int LINE_WORDS  = 4,
   parameter int PRI_LINES   = 16,
   parameter int VIC_ENTRIES = 4,
   parameter int OFF_W       = $clog2(LINE_WORDS),
   parameter int LA_W        = ADDR_W - OFF_W,
   parameter int LINE_W      = DATA_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [LA_W-1:0]   mem_req_addr,
   output logic [LINE_W-1:0] mem_req_wdata,
   input  logic              mem_resp_valid,
   input  logic [LINE_W-1:0] mem_resp_rdata
);
   localparam int IDX_W = $clog2(PRI_LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int SEL_W = $clog2(VIC_ENTRIES);

   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (PRI_LINES < 2 || (PRI_LINES & (PRI_LINES - 1)) != 0) begin : g_bad_lines
      $error("PRI_LINES must be a power of two, at least 2");
   end
   if (VIC_ENTRIES < 2 || VIC_ENTRIES >= PRI_LINES) begin : g_bad_vic
      $error("VIC_ENTRIES must be at least 2 and below PRI_LINES");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   logic [IDX_W-1:0]  pri_rd_idx;
   logic              pri_rd_valid, pri_rd_dirty;
   logic [TAG_W-1:0]  pri_rd_tag;
   logic [LINE_W-1:0] pri_rd_data;
   logic              pri_wr_en, pri_wr_dirty;
   logic [IDX_W-1:0]  pri_wr_idx;
   logic [TAG_W-1:0]  pri_wr_tag;
   logic [LINE_W-1:0] pri_wr_data;
   logic [LA_W-1:0]   vic_lk_addr;
   logic              vic_lk_hit, vic_lk_dirty;
   logic [SEL_W-1:0]  vic_lk_sel;
   logic [LINE_W-1:0] vic_lk_data;
   logic [SEL_W-1:0]  vic_head_sel;
   logic              vic_head_valid, vic_head_dirty;
   logic [LA_W-1:0]   vic_head_addr;
   logic [LINE_W-1:0] vic_head_data;
   logic              vic_wr_en, vic_wr_valid, vic_wr_dirty, vic_push;
   logic [SEL_W-1:0]  vic_wr_sel;
   logic [LA_W-1:0]   vic_wr_addr;
   logic [LINE_W-1:0] vic_wr_data;

   vc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .SEL_W(SEL_W), .TAG_W(TAG_W), .LA_W(LA_W), .LINE_W(LINE_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
      .mem_resp_rdata(mem_resp_rdata),
      .pri_rd_idx(pri_rd_idx), .pri_rd_valid(pri_rd_valid), .pri_rd_dirty(pri_rd_dirty),
      .pri_rd_tag(pri_rd_tag), .pri_rd_data(pri_rd_data),
      .pri_wr_en(pri_wr_en), .pri_wr_idx(pri_wr_idx), .pri_wr_tag(pri_wr_tag),
      .pri_wr_data(pri_wr_data), .pri_wr_dirty(pri_wr_dirty),
      .vic_lk_addr(vic_lk_addr), .vic_lk_hit(vic_lk_hit), .vic_lk_sel(vic_lk_sel),
      .vic_lk_data(vic_lk_data), .vic_lk_dirty(vic_lk_dirty),
      .vic_head_sel(vic_head_sel), .vic_head_valid(vic_head_valid),
      .vic_head_dirty(vic_head_dirty), .vic_head_addr(vic_head_addr),
      .vic_head_data(vic_head_data),
      .vic_wr_en(vic_wr_en), .vic_wr_sel(vic_wr_sel), .vic_wr_valid(vic_wr_valid),
      .vic_wr_addr(vic_wr_addr), .vic_wr_data(vic_wr_data), .vic_wr_dirty(vic_wr_dirty),
      .vic_push(vic_push)
   );

   vc_primary_array #(
      .LINES(PRI_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
   ) i_pri (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pri_rd_idx), .rd_valid(pri_rd_valid), .rd_dirty(pri_rd_dirty),
      .rd_tag(pri_rd_tag), .rd_data(pri_rd_data),
      .wr_en(pri_wr_en), .wr_idx(pri_wr_idx), .wr_tag(pri_wr_tag),
      .wr_data(pri_wr_data), .wr_dirty(pri_wr_dirty)
   );

   vc_victim_buffer #(
      .ENTRIES(VIC_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W), .SEL_W(SEL_W)
   ) i_vic (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(vic_lk_addr), .lk_hit(vic_lk_hit), .lk_sel(vic_lk_sel),
      .lk_data(vic_lk_data), .lk_dirty(vic_lk_dirty),
      .head_sel(vic_head_sel), .head_valid(vic_head_valid), .head_dirty(vic_head_dirty),
      .head_addr(vic_head_addr), .head_data(vic_head_data),
      .wr_en(vic_wr_en), .wr_sel(vic_wr_sel), .wr_valid(vic_wr_valid),
      .wr_addr(vic_wr_addr), .wr_data(vic_wr_data), .wr_dirty(vic_wr_dirty),
      .push(vic_push)
   );
endmodule

// File: rtl/vc_cache_checker.sv
module vc_cache_checker #(
   parameter int LA_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            resp_valid,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic            mem_req_write,
   input logic [LA_W-1:0] mem_req_addr
);
   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !resp_valid && !mem_req_valid)); // R1

   AST_RESP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready); // R2

   AST_PROBE_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !(mem_req_valid && !mem_req_write)); // R4

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R8

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R8
endmodule

bind vc_cache_top vc_cache_checker #(.LA_W(LA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .resp_valid(resp_valid), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr)
);

// File: tb/test_vc_cache_top.sv
module test_vc_cache_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [1:0]  cls;   // 1 primary hit, 2 victim hit, 3 full miss
      logic [3:0]  wbs;   // expected write-back count after the request
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 12'h04C, 32'h0,         2'd3, 4'd0},
      '{1'b0, 12'h04D, 32'h0,         2'd1, 4'd0},
      '{1'b1, 12'h04E, 32'h1111_2222, 2'd1, 4'd0},
      '{1'b0, 12'h08C, 32'h0,         2'd3, 4'd0},
      '{1'b0, 12'h04E, 32'h0,         2'd2, 4'd0},
      '{1'b0, 12'h08D, 32'h0,         2'd2, 4'd0},
      '{1'b1, 12'h0CF, 32'hDEAD_BEEF, 2'd3, 4'd0},
      '{1'b0, 12'h0CF, 32'h0,         2'd1, 4'd0},
      '{1'b0, 12'h10C, 32'h0,         2'd3, 4'd0},
      '{1'b0, 12'h14C, 32'h0,         2'd3, 4'd0},
      '{1'b0, 12'h18C, 32'h0,         2'd3, 4'd1},
      '{1'b0, 12'h04E, 32'h0,         2'd3, 4'd1},
      '{1'b0, 12'h0CF, 32'h0,         2'd2, 4'd1},
      '{1'b0, 12'h054, 32'h0,         2'd3, 4'd1},
      '{1'b0, 12'h054, 32'h0,         2'd1, 4'd1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic         req_write = 1'b0;
   logic [11:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic         resp_valid;
   logic [31:0]  resp_rdata;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b1;
   logic         mem_req_write;
   logic [9:0]   mem_req_addr;
   logic [127:0] mem_req_wdata;
   logic         mem_resp_valid = 1'b0;
   logic [127:0] mem_resp_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   logic [31:0]  shadow [4096];
   logic [127:0] mem [1024];
   int           rd_cnt = 0;
   logic [9:0]   rd_la = '0;
   int           n_reads = 0;
   int           n_wbs = 0;
   logic [9:0]   last_rd = '0;
   logic [9:0]   last_wb_addr = '0;
   logic [127:0] last_wb_data = '0;

   vc_cache_top i_vc_cache_top (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
      .mem_resp_rdata(mem_resp_rdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] pattern(input int a);
      return {8'hA5, 12'(a), 12'(a ^ 12'hFFF)};
   endfunction

   // next-level memory model: reads return after a short delay, writes are posted
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_cnt = 0;
         mem_resp_valid = 1'b0;
      end else begin
         mem_resp_valid = 1'b0;
         if (rd_cnt != 0) begin
            rd_cnt = rd_cnt - 1;
            if (rd_cnt == 0) begin
               mem_resp_valid = 1'b1;
               mem_resp_rdata = mem[rd_la];
            end
         end
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem[mem_req_addr] = mem_req_wdata;
               n_wbs = n_wbs + 1;
               last_wb_addr = mem_req_addr;
               last_wb_data = mem_req_wdata;
            end else begin
               rd_la = mem_req_addr;
               last_rd = mem_req_addr;
               n_reads = n_reads + 1;
               rd_cnt = 3;
            end
         end
      end
   end

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         output int lat, output logic [31:0] rd, output logic busy_ready);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid  = 1'b0;
      lat        = 1;
      busy_ready = req_ready;
      while (!resp_valid && lat < 500) begin
         @(negedge clk);
         lat++;
      end
      rd = resp_rdata;
      if (wr) shadow[a] = d;
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [31:0] rd;
      logic bsy;
      int reads_before;
      int cls;
      for (int i = 0; i < 4096; i++) shadow[i] = pattern(i);
      for (int l = 0; l < 1024; l++)
         mem[l] = {pattern(l*4+3), pattern(l*4+2), pattern(l*4+1), pattern(l*4)};

      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1", "req_ready in reset", 128'(req_ready), 128'(1'b1));
      check("R1", "resp_valid in reset", 128'(resp_valid), 128'(1'b0));
      check("R1", "mem_req_valid in reset", 128'(mem_req_valid), 128'(1'b0));
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         reads_before = n_reads;
         do_req(VEC[v].wr, VEC[v].addr, VEC[v].wdata, lat, rd, bsy);
         cls = (lat == 1) ? 1 : (lat == 2) ? 2 : 3;
         // R2 primary hit, R4/R5 victim hit, R1/R6 full miss latency class
         check(VEC[v].cls == 2'd1 ? "R2" : VEC[v].cls == 2'd2 ? "R4" : "R6",
               $sformatf("latency class vec %0d", v), 128'(cls), 128'(VEC[v].cls));
         if (!VEC[v].wr)
            check("R9", $sformatf("read data vec %0d", v), 128'(rd), 128'(shadow[VEC[v].addr]));
         // R7: write-back count follows FIFO wrap and dirty state
         check("R7", $sformatf("write-back count vec %0d", v), 128'(n_wbs), 128'(VEC[v].wbs));
         if (VEC[v].cls == 2'd3) begin
            check("R8", $sformatf("read line address vec %0d", v),
                  128'(last_rd), 128'(VEC[v].addr[11:2]));
            check("R8", $sformatf("ready low while busy vec %0d", v), 128'(bsy), 128'(1'b0));
         end else begin
            check(VEC[v].cls == 2'd1 ? "R3" : "R4",
                  $sformatf("no memory read on hit vec %0d", v),
                  128'(n_reads), 128'(reads_before));
         end
         if (v == 10) begin
            // R7: oldest dirty entry left with its own address and merged data
            check("R7", "write-back line address", 128'(last_wb_addr), 128'(10'h013));
            check("R7", "write-back line data", last_wb_data,
                  {shadow[12'h04F], shadow[12'h04E], shadow[12'h04D], shadow[12'h04C]});
         end
      end

      // R3: write miss allocates and merges into the fetched line
      do_req(1'b1, 12'h1D1, 32'h0BAD_F00D, lat, rd, bsy);
      check("R3", "write miss latency class", 128'(lat > 2), 128'(1'b1));
      do_req(1'b0, 12'h1D1, 32'h0, lat, rd, bsy);
      check("R3", "merged word after write miss", 128'(rd), 128'(32'h0BAD_F00D));
      do_req(1'b0, 12'h1D0, 32'h0, lat, rd, bsy);
      check("R3", "untouched neighbour word", 128'(rd), 128'(shadow[12'h1D0]));
      check("R3", "neighbour read is a hit", 128'(lat), 128'(1));

      // R1: reset mid-run clears valid bits
      pulse_reset();
      check("R1", "req_ready after second reset", 128'(req_ready), 128'(1'b1));
      check("R1", "resp_valid after second reset", 128'(resp_valid), 128'(1'b0));
      reads_before = n_reads;
      do_req(1'b0, 12'h054, 32'h0, lat, rd, bsy);
      check("R1", "former hit misses after reset", 128'(n_reads), 128'(reads_before + 1));
      check("R9", "data after reset refill", 128'(rd), 128'(shadow[12'h054]));

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule